// File: doc/BRIEF.md
# Host Byte-Write Word Assembler

This block is the transmit half of a narrow host port that feeds a wide processor. An 8-bit host writes a 24-bit word one byte at a time into three write-only byte lanes (high, middle, low). A 3-bit host address picks the lane, and a swap control decides whether the high lane sits at the top or the bottom of the three-address window. The write to the topmost address marks the word as complete. The block then hands the whole word to a processor-side holding register once that register is free.

Two flags govern the handoff. One is a transmit-empty flag shown to the host. The other is a receive-full flag on the processor side, which the processor clears by reading the word. The host-visible copy of transmit-empty lags the internal state by two cycles, which models a status pipeline. A host request output can be enabled so that it follows the empty flag. A hardware reset, a software reset and a port-enable clear each return the block to its idle state.

Top module: `host_tx_assembler`

## Requirements
- R1: The three byte lanes form the 24-bit word as {high, middle, low}, and a transfer copies all three lanes into `rx_word` at once.
- R2: With `hi_at_top`=1, address 7 writes the high lane, address 6 the middle lane and address 5 the low lane. With `hi_at_top`=0, address 5 writes the high lane, address 6 the middle lane and address 7 the low lane.
- R3: Host writes to addresses 0 to 4 change no byte lane and no flag.
- R4: A host write to address 7 clears the internal empty flag at that edge, whatever lane address 7 maps to. If `rx_full` is low, the word moves to `rx_word` on the next edge, and that edge sets both the empty flag and `rx_full`.
- R5: While `rx_full` is high, a completed word is held and `rx_word` stays unchanged. A `proc_rd` pulse clears `rx_full` at its edge, and the held word transfers on the following edge.
- R6: `host_tx_empty` shows the internal empty flag delayed by exactly two clock cycles, so a status read within two cycles of a write returns the old value.
- R7: `host_req` is high exactly when `req_en` was high in the previous cycle and `host_tx_empty` is high.
- R8: `rst`, `sw_rst`, or `host_en` held low each zero the byte lanes and `rx_word`, set `host_tx_empty`, clear `rx_full` and drop `host_req`.
- R9: If a write to address 7 falls in the same cycle as a transfer, the transfer moves the old lanes and the write wins the empty flag. The new word stays pending until the next transfer.
- R10: A host write made while the word is not yet empty still loads its addressed lane, and the next transfer carries that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| host_en | input | 1 | Port enable; low holds the block in reset |
| hi_at_top | input | 1 | Lane order select: 1 puts the high lane at address 7 |
| req_en | input | 1 | Host request enable |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_data | input | 8 | Host write data |
| proc_rd | input | 1 | Processor read of the received word |
| host_tx_empty | output | 1 | Transmit-empty flag as seen by the host, delayed two cycles |
| host_req | output | 1 | Host request: ready for a new word |
| rx_word | output | 24 | Processor-side received word |
| rx_full | output | 1 | Processor-side receive-full flag |

## Verification
Two functions can fall in the same cycle: a commit write to address 7 and a transfer of the previous word. The bench provokes this by issuing two commit writes on back-to-back edges while `rx_full` is low. The second write lands on the very edge where the first word transfers. The bench judges the result by checking three things: `rx_word` carries the first byte, `host_tx_empty` stays low after its two-cycle delay, and a later `proc_rd` delivers a word carrying the second byte. A second overlap also gets its own check: a processor read clears `rx_full` while a word is pending, and the transfer must follow on exactly the next edge.

// File: rtl/hta_pkg.sv
package hta_pkg;
  // Sizes shared by the assembler and its bench
  localparam int HTA_BYTE_W = 8;
  localparam int HTA_NBYTES = 3;
  localparam int HTA_ADDR_W = 3;
  localparam int HTA_FLAG_DELAY = 2;

  // Lane index written by a host address, or -1 outside the window
  function automatic int lane_of(input int addr, input logic hi_top,
                                 input int addr_w, input int nbytes);
    int base;
    int top;
    base = (1 << addr_w) - nbytes;
    top  = (1 << addr_w) - 1;
    if (addr < base || addr > top) return -1;
    return hi_top ? (addr - base) : (top - addr);
  endfunction
endpackage

// File: rtl/hta_addr_decode.sv
module hta_addr_decode #(
  parameter int ADDR_W = 3,
  parameter int NBYTES = 3
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hi_top,
  output logic [NBYTES-1:0] lane_we,
  output logic              commit
);
  localparam int BASE = (1 << ADDR_W) - NBYTES;
  localparam int TOP  = (1 << ADDR_W) - 1;
  localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(TOP);

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    localparam logic [ADDR_W-1:0] UP_A = ADDR_W'(BASE + i);
    localparam logic [ADDR_W-1:0] DN_A = ADDR_W'(TOP - i);
    assign lane_we[i] = wr && (hi_top ? (addr == UP_A) : (addr == DN_A));
  end

  assign commit = wr && (addr == TOP_A);
endmodule

// File: rtl/hta_byte_lanes.sv
module hta_byte_lanes #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  localparam int WORD_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBYTES-1:0] we,
  input  logic [BYTE_W-1:0] din,
  output logic [WORD_W-1:0] lanes_q
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (we[i]) q <= din;
    end
    assign lanes_q[i*BYTE_W +: BYTE_W] = q;

    assert_lane_load_R1: assert property (@(posedge clk) disable iff (rst)
      we[i] |=> (q == $past(din)));
  end

  assert_single_lane_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we));
endmodule

// File: rtl/hta_status_pipe.sv
module hta_status_pipe #(
  parameter int   DEPTH   = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic q_pre
);
  logic [DEPTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {DEPTH{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];

  if (DEPTH == 1) begin : g_pre_in
    assign q_pre = d;
  end else begin : g_pre_stg
    assign q_pre = stg[DEPTH-2];
  end
endmodule

// File: rtl/host_tx_assembler.sv
module host_tx_assembler #(
  parameter int BYTE_W     = hta_pkg::HTA_BYTE_W,
  parameter int NBYTES     = hta_pkg::HTA_NBYTES,
  parameter int ADDR_W     = hta_pkg::HTA_ADDR_W,
  parameter int FLAG_DELAY = hta_pkg::HTA_FLAG_DELAY
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sw_rst,
  input  logic                     host_en,
  input  logic                     hi_at_top,
  input  logic                     req_en,
  input  logic                     host_wr,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [BYTE_W-1:0]        host_data,
  input  logic                     proc_rd,
  output logic                     host_tx_empty,
  output logic                     host_req,
  output logic [BYTE_W*NBYTES-1:0] rx_word,
  output logic                     rx_full
);
  localparam int WORD_W = BYTE_W * NBYTES;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'((1 << ADDR_W) - NBYTES);
  localparam logic [ADDR_W-1:0] TOP_A  = ADDR_W'((1 << ADDR_W) - 1);

  logic              any_rst;
  logic [NBYTES-1:0] lane_we;
  logic              commit;
  logic [WORD_W-1:0] lanes_q;
  logic              txde_r;
  logic              rxf_r;
  logic              xfer;
  logic              pipe_pre;

  // All three reset sources act alike
  assign any_rst = rst | sw_rst | ~host_en;

  hta_addr_decode #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_dec (
    .wr(host_wr), .addr(host_addr), .hi_top(hi_at_top),
    .lane_we(lane_we), .commit(commit)
  );

  hta_byte_lanes #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_lanes (
    .clk(clk), .rst(any_rst), .we(lane_we), .din(host_data), .lanes_q(lanes_q)
  );

  // Handoff fires when a word is pending and the holding register is free
  assign xfer = ~txde_r & ~rxf_r;

  always_ff @(posedge clk) begin
    if (any_rst) begin
      txde_r  <= 1'b1;
      rxf_r   <= 1'b0;
      rx_word <= '0;
    end else begin
      if (xfer) begin
        rx_word <= lanes_q;
        rxf_r   <= 1'b1;
      end else if (proc_rd) begin
        rxf_r   <= 1'b0;
      end
      // A commit in the transfer cycle leaves the next word pending
      if (commit)    txde_r <= 1'b0;
      else if (xfer) txde_r <= 1'b1;
    end
  end

  assign rx_full = rxf_r;

  hta_status_pipe #(.DEPTH(FLAG_DELAY), .RST_VAL(1'b1)) u_stat (
    .clk(clk), .rst(any_rst), .d(txde_r), .q(host_tx_empty), .q_pre(pipe_pre)
  );

  always_ff @(posedge clk) begin
    if (any_rst) host_req <= 1'b0;
    else         host_req <= req_en & pipe_pre;
  end

  // Assertion support: cycles since the last reset, saturating at 2
  logic [1:0] chk_age;
  always_ff @(posedge clk) begin
    if (any_rst)             chk_age <= 2'd0;
    else if (chk_age != 2'd2) chk_age <= chk_age + 2'd1;
  end

  assert_low_addr_ignored_R3: assert property (@(posedge clk) disable iff (any_rst)
    (chk_age != 2'd0 && host_wr && host_addr < BASE_A) |=> $stable(lanes_q));

  assert_commit_clears_R4: assert property (@(posedge clk) disable iff (any_rst)
    (host_wr && host_addr == TOP_A) |=> !txde_r);

  assert_xfer_sets_flags_R4: assert property (@(posedge clk) disable iff (any_rst)
    (!txde_r && !rxf_r && !commit) |=> (txde_r && rxf_r));

  assert_hold_while_full_R5: assert property (@(posedge clk) disable iff (any_rst)
    (chk_age != 2'd0 && rxf_r && !proc_rd) |=> (rxf_r && $stable(rx_word)));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (any_rst)
    (proc_rd && rxf_r) |=> !rxf_r);

  assert_req_follows_flag_R7: assert property (@(posedge clk) disable iff (any_rst)
    (chk_age != 2'd0) |-> (host_req == ($past(req_en) && host_tx_empty)));

  assert_collide_keeps_pending_R9: assert property (@(posedge clk) disable iff (any_rst)
    (host_wr && host_addr == TOP_A && !txde_r && !rxf_r) |=> (!txde_r && rxf_r));

  if (FLAG_DELAY == 2) begin : g_delay_chk
    assert_status_delay_R6: assert property (@(posedge clk) disable iff (any_rst)
      (chk_age == 2'd2) |-> (host_tx_empty == $past(txde_r, 2)));
  end
endmodule

// File: tb/host_tx_assembler_tb.sv
`timescale 1ns/1ps
module host_tx_assembler_tb;
  localparam int BW = hta_pkg::HTA_BYTE_W;
  localparam int NB = hta_pkg::HTA_NBYTES;
  localparam int AW = hta_pkg::HTA_ADDR_W;
  localparam int WW = BW * NB;

  logic clk = 1'b0;
  logic rst = 1'b1, sw_rst = 1'b0, host_en = 1'b1, hi_at_top = 1'b0, req_en = 1'b0;
  logic host_wr = 1'b0, proc_rd = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [BW-1:0] host_data = '0;
  logic host_tx_empty, host_req, rx_full;
  logic [WW-1:0] rx_word;

  int n_chk = 0, n_fail = 0, n_proto = 0;
  logic [BW-1:0] m_lane [NB];
  logic done = 1'b0;

  always #4 clk = ~clk;

  host_tx_assembler u_dut (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .host_en(host_en), .hi_at_top(hi_at_top),
    .req_en(req_en), .host_wr(host_wr), .host_addr(host_addr), .host_data(host_data),
    .proc_rd(proc_rd), .host_tx_empty(host_tx_empty), .host_req(host_req),
    .rx_word(rx_word), .rx_full(rx_full)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] model_word();
    logic [WW-1:0] w;
    for (int i = 0; i < NB; i++) w[i*BW +: BW] = m_lane[i];
    return w;
  endfunction

  function automatic void model_write(input int a, input logic [BW-1:0] d);
    int l;
    l = hta_pkg::lane_of(a, hi_at_top, AW, NB);
    if (l >= 0) m_lane[l] = d;
  endfunction

  task automatic wr(input int a, input logic [BW-1:0] d);
    @(negedge clk);
    if (!host_tx_empty) n_proto++;
    host_wr = 1'b1; host_addr = AW'(a); host_data = d;
    model_write(a, d);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); proc_rd = 1'b1;
    @(negedge clk); proc_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // kind 0: hardware, 1: software, 2: enable clear
  task automatic do_reset(input int kind, input string tag);
    @(negedge clk);
    if (kind == 0) rst = 1'b1; else if (kind == 1) sw_rst = 1'b1; else host_en = 1'b0;
    @(negedge clk);
    check({tag, " empty"}, 32'(host_tx_empty), 32'd1);
    check({tag, " full"},  32'(rx_full), 32'd0);
    check({tag, " word"},  32'(rx_word), 32'd0);
    check({tag, " req"},   32'(host_req), 32'd0);
    rst = 1'b0; sw_rst = 1'b0; host_en = 1'b1;
    for (int i = 0; i < NB; i++) m_lane[i] = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] w_old, w1, w2;
    for (int i = 0; i < NB; i++) m_lane[i] = '0;
    for (int be = 0; be < 2; be++) begin
      hi_at_top = be[0];
      req_en = 1'b1;
      do_reset(0, "R8 hw");

      // R3: low addresses leave lanes and flags alone
      for (int a = 0; a < 5; a++) wr(a, BW'(8'hA0 + a + 16 * be));
      idle(3);
      check("R3 empty", 32'(host_tx_empty), 32'd1);
      check("R3 full",  32'(rx_full), 32'd0);

      // R4/R6: commit alone, then watch flag pipeline
      wr(7, BW'(8'h5C + be));
      check("R6 old status", 32'(host_tx_empty), 32'd1);
      check("R4 not yet", 32'(rx_full), 32'd0);
      @(negedge clk);
      check("R4 full", 32'(rx_full), 32'd1);
      check("R3 R2 word", 32'(rx_word), 32'(model_word()));
      check("R6 still old", 32'(host_tx_empty), 32'd1);
      @(negedge clk);
      check("R6 low", 32'(host_tx_empty), 32'd0);
      check("R7 req low", 32'(host_req), 32'd0);
      @(negedge clk);
      check("R6 back", 32'(host_tx_empty), 32'd1);
      check("R7 req high", 32'(host_req), 32'd1);

      // R5/R2/R10: full word held behind a full register
      w_old = rx_word;
      wr(5, BW'(8'h11 + be));
      wr(6, BW'(8'h22 + be));
      check("R4 no commit", 32'(rx_word), 32'(w_old));
      wr(7, BW'(8'h33 + be));
      idle(3);
      check("R5 held word", 32'(rx_word), 32'(w_old));
      check("R5 held empty", 32'(host_tx_empty), 32'd0);
      check("R5 held full", 32'(rx_full), 32'd1);
      wr(6, BW'(8'h66 + be));
      rd_pulse();
      check("R5 cleared", 32'(rx_full), 32'd0);
      check("R5 word kept", 32'(rx_word), 32'(w_old));
      @(negedge clk);
      check("R5 full again", 32'(rx_full), 32'd1);
      check("R1 R2 R10 word", 32'(rx_word), 32'(model_word()));
      idle(2);
      check("R5 empty again", 32'(host_tx_empty), 32'd1);

      // R7: no request when disabled
      req_en = 1'b0;
      idle(2);
      check("R7 req disabled", 32'(host_req), 32'd0);
      req_en = 1'b1;

      // R9: commit lands on the transfer edge
      rd_pulse();
      @(negedge clk);
      host_wr = 1'b1; host_addr = 3'd7; host_data = BW'(8'hD1 + be);
      model_write(7, host_data); w1 = model_word();
      @(negedge clk);
      host_data = BW'(8'hE2 + be);
      model_write(7, host_data); w2 = model_word();
      @(negedge clk);
      host_wr = 1'b0;
      check("R9 first word", 32'(rx_word), 32'(w1));
      check("R9 full", 32'(rx_full), 32'd1);
      idle(3);
      check("R9 pending", 32'(host_tx_empty), 32'd0);
      rd_pulse();
      @(negedge clk);
      check("R9 second word", 32'(rx_word), 32'(w2));

      // R8: software reset zeroes lanes
      wr(5, BW'(8'h77));
      do_reset(1, "R8 sw");
      wr(7, BW'(8'h99));
      @(negedge clk);
      check("R8 sw lanes", 32'(rx_word), 32'(model_word()));

      // R8: enable clear
      wr(6, BW'(8'h44));
      do_reset(2, "R8 en");
      wr(7, BW'(8'h3C));
      @(negedge clk);
      check("R8 en lanes", 32'(rx_word), 32'(model_word()));
    end
    $display("note: %0d host writes made while not empty", n_proto);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule